// File: doc/BRIEF.md
# Time-Slotted PCM Audio Port

This block is one participant on a shared four-wire PCM audio link made of a bit clock, a frame sync pulse, a serial line toward the bus and a serial line from the bus. Each frame is divided into equal time slots of `W` bit periods, and several devices share the bus by each taking a different slot. The block is told which slot is its own and how many slots a frame holds. In its own slot it sends one parallel word, most significant bit first, and it raises an output-enable so that other devices can drive the line in the remaining slots. In the same slot it collects one word from the receive line and presents it on a parallel output with a one-cycle strobe.

The bit clock, frame sync and receive data come from an external master. They are resynchronised into the block's system clock and oversampled there, so the whole block runs in a single clock domain. The block drives its serial output on falling bit-clock edges and samples on rising edges. Two alignment modes are supported. In the first, the sync pulse sits one bit period before the first MSB of the frame. In the second, the sync pulse shares its bit period with that MSB. The block keeps a free-running bit position that wraps at the frame length, so a lost sync pulse does not lose alignment. Any sync pulse that is seen forces the position to a new value.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset `txd`, `txd_oe`, `rx_valid` and `rx_word` are 0. No slot is transmitted and no word is strobed until a sync pulse has been seen.
- R2: With `mode_b`=0 the sync pulse occupies the bit period just before the slot-0 MSB. With `mode_b`=1 the sync pulse occupies the same bit period as the slot-0 MSB.
- R3: A frame lasts `slot_cnt`×`W` bit periods. The block's slot covers bit positions `slot_idx`×`W` through `slot_idx`×`W`+`W`−1, where position 0 carries the slot-0 MSB.
- R4: `txd_oe` is 1 for exactly the `W` bit periods of the block's own slot and 0 in all other periods. It changes only in response to a falling bit-clock edge.
- R5: The transmitted word goes out MSB first, one bit per period. `tx_word` is captured at the falling edge that opens the block's slot.
- R6: Receive bits are sampled on rising bit-clock edges, MSB first, during the block's slot only. After the slot's last bit, `rx_word` is updated and `rx_valid` pulses for one clock. Data in other slots has no effect on `rx_word`.
- R7: When a sync pulse is missing, the position keeps counting modulo the frame length, and data stays aligned.
- R8: A sync pulse arriving at an unexpected position realigns the frame from that pulse. Traffic is correct again from the next full frame.
- R9: `txd` is 0 whenever `txd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the link |
| rst | input | 1 | Synchronous active-high reset |
| mode_b | input | 1 | 0: sync precedes the slot-0 MSB; 1: sync coincides with the slot-0 MSB |
| slot_idx | input | $clog2(MAX_SLOTS) | Index of the block's own slot |
| slot_cnt | input | $clog2(MAX_SLOTS+1) | Number of slots per frame (1..MAX_SLOTS) |
| bclk | input | 1 | Link bit clock from the master |
| fsync | input | 1 | Frame sync, one bit period wide |
| rxd | input | 1 | Serial data from the bus |
| tx_word | input | W | Word to send in the next own slot |
| txd | output | 1 | Serial data toward the bus |
| txd_oe | output | 1 | Drive enable for `txd`, high only in own slot |
| rx_word | output | W | Last word received in own slot |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |

## Verification
A wrong bit position shows at the ports within one frame. `txd_oe` rises in a period outside the configured slot, the transmitted word comes out rotated, or `rx_valid` arrives at the wrong time with a shifted word. A corrupted lock state shows either as a missing strobe on the first full frame or as bus drive before any sync has been seen. Errors in the transmit shift register show as wrong bits in the very slot where they occur. Every frame carries fresh random words in both directions, and the other slots are filled with noise, so a slip of even one position mismatches at least one captured word.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  // Frame alignment: where the sync pulse sits relative to the slot-0 MSB
  typedef enum logic {
    ALIGN_EARLY = 1'b0,  // sync one bit period before the MSB
    ALIGN_SAME  = 1'b1   // sync in the MSB's bit period
  } align_e;
endpackage

// File: rtl/pcm_bclk_edge.sv
module pcm_bclk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic fsync,
  input  logic rxd,
  output logic rise,
  output logic fall,
  output logic fsync_s,
  output logic rxd_s
);
  logic [2:0] raw;
  logic [2:0] synced;
  logic       bclk_q;

  assign raw = {bclk, fsync, rxd};

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign synced = raw;
    end else begin : g_sync
      logic [2:0] stage [SYNC_STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
        end else begin
          stage[0] <= raw;
          for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
        end
      end
      assign synced = stage[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bclk_q <= 1'b0;
    else     bclk_q <= synced[2];
  end

  assign rise    = synced[2] & ~bclk_q;
  assign fall    = ~synced[2] & bclk_q;
  assign fsync_s = synced[1];
  assign rxd_s   = synced[0];
endmodule

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos
  import pcm_tdm_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          fsync,
  input  logic          mode_b,
  input  logic [LW-1:0] frame_len,
  output logic [LW-1:0] samp_pos,
  output logic [LW-1:0] launch_pos,
  output logic [LW-1:0] pos_q,
  output logic          locked
);
  align_e        align;
  logic [LW-1:0] last;
  logic [LW-1:0] step;

  assign align = align_e'(mode_b);
  assign last  = frame_len - LW'(1);
  assign step  = (pos_q >= last) ? '0 : pos_q + LW'(1);

  // Position of the bit sampled at this rising edge
  always_comb begin
    if (fsync) samp_pos = (align == ALIGN_SAME) ? '0 : last;
    else       samp_pos = step;
  end

  // Position of the bit period opened by the next falling edge
  assign launch_pos = step;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      locked <= 1'b0;
    end else if (rise) begin
      pos_q <= samp_pos;
      if (fsync) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          locked,
  input  logic [LW-1:0] launch_pos,
  input  logic [LW-1:0] first,
  input  logic [W-1:0]  tx_word,
  output logic          txd,
  output logic          txd_oe
);
  logic [W-1:0] sh;
  logic         in_slot;
  logic         at_first;

  assign in_slot  = (launch_pos >= first) && (launch_pos < first + LW'(W));
  assign at_first = (launch_pos == first);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      txd    <= 1'b0;
      txd_oe <= 1'b0;
    end else if (fall) begin
      if (locked && in_slot && (at_first || txd_oe)) begin
        txd_oe <= 1'b1;
        if (at_first) begin
          txd <= tx_word[W-1];
          sh  <= {tx_word[W-2:0], 1'b0};
        end else begin
          txd <= sh[W-1];
          sh  <= {sh[W-2:0], 1'b0};
        end
      end else begin
        txd_oe <= 1'b0;
        txd    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          locked,
  input  logic [LW-1:0] samp_pos,
  input  logic [LW-1:0] first,
  input  logic          rxd,
  output logic [W-1:0]  rx_word,
  output logic          rx_valid
);
  logic [W-1:0] sh;
  logic         in_slot;
  logic         at_last;

  assign in_slot = (samp_pos >= first) && (samp_pos < first + LW'(W));
  assign at_last = (samp_pos == first + LW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise && in_slot) begin
        sh <= {sh[W-2:0], rxd};
        if (at_last && locked) begin
          rx_word  <= {sh[W-2:0], rxd};
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int W           = 16,
  parameter int MAX_SLOTS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int CW = $clog2(MAX_SLOTS + 1),
  localparam int LW = $clog2(MAX_SLOTS * W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_b,
  input  logic [IW-1:0] slot_idx,
  input  logic [CW-1:0] slot_cnt,
  input  logic          bclk,
  input  logic          fsync,
  input  logic          rxd,
  input  logic [W-1:0]  tx_word,
  output logic          txd,
  output logic          txd_oe,
  output logic [W-1:0]  rx_word,
  output logic          rx_valid
);
  logic          rise, fall, fsync_s, rxd_s;
  logic [LW-1:0] frame_len, first;
  logic [LW-1:0] samp_pos, launch_pos, pos_q;
  logic          locked;

  assign frame_len = LW'(slot_cnt) * LW'(W);
  assign first     = LW'(slot_idx) * LW'(W);

  pcm_bclk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .rxd(rxd),
    .rise(rise), .fall(fall), .fsync_s(fsync_s), .rxd_s(rxd_s)
  );

  pcm_frame_pos #(.LW(LW)) u_pos (
    .clk(clk), .rst(rst), .rise(rise), .fsync(fsync_s), .mode_b(mode_b),
    .frame_len(frame_len), .samp_pos(samp_pos), .launch_pos(launch_pos),
    .pos_q(pos_q), .locked(locked)
  );

  pcm_tx_slot #(.W(W), .LW(LW)) u_tx (
    .clk(clk), .rst(rst), .fall(fall), .locked(locked),
    .launch_pos(launch_pos), .first(first), .tx_word(tx_word),
    .txd(txd), .txd_oe(txd_oe)
  );

  pcm_rx_slot #(.W(W), .LW(LW)) u_rx (
    .clk(clk), .rst(rst), .rise(rise), .locked(locked),
    .samp_pos(samp_pos), .first(first), .rxd(rxd_s),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk #(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          fall,
  input logic          txd_oe,
  input logic          rx_valid,
  input logic [W-1:0]  rx_word,
  input logic          locked,
  input logic [LW-1:0] pos_q,
  input logic [LW-1:0] frame_len
);
  // R4: enable moves only after a detected falling bit-clock edge
  a_r4_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd_oe) |-> $past(fall));

  // R6: strobe lasts one clock
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6: received word changes only together with the strobe
  a_r6_word_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word) |-> rx_valid);

  // R1: no bus drive before a sync pulse was seen
  a_r1_oe_needs_lock: assert property (@(posedge clk) disable iff (rst)
    txd_oe |-> locked);

  // R1: no strobe before a sync pulse was seen
  a_r1_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> locked);

  // R3: bit position stays inside the frame
  a_r3_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
    pos_q < frame_len);
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.W(W), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .fall(fall), .txd_oe(txd_oe), .rx_valid(rx_valid),
  .rx_word(rx_word), .locked(locked), .pos_q(pos_q), .frame_len(frame_len)
);

// File: tb/test_pcm_tdm_port.sv
`timescale 1ns/1ps
module test_pcm_tdm_port;
  localparam int W  = 16;
  localparam int MS = 8;
  localparam int IW = $clog2(MS);
  localparam int CW = $clog2(MS + 1);
  localparam int NF = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_b = 1'b0;
  logic [IW-1:0] slot_idx = '0;
  logic [CW-1:0] slot_cnt = CW'(1);
  logic          bclk = 1'b0, fsync = 1'b0, rxd = 1'b0;
  logic [W-1:0]  tx_word = '0;
  logic          txd, txd_oe, rx_valid;
  logic [W-1:0]  rx_word;

  int checks = 0, fails = 0, vcount = 0;
  logic [W-1:0] last_rx = '0;

  always #2.5 clk = ~clk;

  pcm_tdm_port #(.W(W), .MAX_SLOTS(MS), .SYNC_STAGES(2)) i_pcm_tdm_port (
    .clk(clk), .rst(rst), .mode_b(mode_b), .slot_idx(slot_idx),
    .slot_cnt(slot_cnt), .bclk(bclk), .fsync(fsync), .rxd(rxd),
    .tx_word(tx_word), .txd(txd), .txd_oe(txd_oe),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (!rst && rx_valid) begin
    vcount++;
    last_rx = rx_word;
  end

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // One bit period: low half 4 clocks, high half 4 clocks
  task automatic bit_period(input logic fs, input logic rb,
                            output logic t, output logic oe);
    @(negedge clk);
    bclk = 1'b0; fsync = fs; rxd = rb;
    repeat (4) @(negedge clk);
    t = txd; oe = txd_oe;
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_config(input logic mb, input int idx, input int cnt,
                            input int drop_f, input int gap_f);
    int L = cnt * W;
    int st = idx * W;
    rst = 1'b1; mode_b = mb; slot_idx = IW'(idx); slot_cnt = CW'(cnt);
    bclk = 1'b0; fsync = 1'b0; rxd = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int f = 0; f < NF; f++) begin
      logic [W-1:0] txw, rxw, got;
      int oe_bad, oe_cnt, t_bad, vstart;
      bit good;
      txw = W'($urandom); rxw = W'($urandom); got = '0;
      oe_bad = 0; oe_cnt = 0; t_bad = 0; vstart = vcount;
      for (int p = 0; p < L; p++) begin
        logic fs, rb, t, oe;
        bit ins;
        ins = (p >= st) && (p < st + W);
        fs = (f != drop_f) && (mb ? (p == 0) : (p == L - 1));
        if (p == st) tx_word = txw;
        rb = ins ? rxw[W-1-(p-st)] : 1'($urandom);
        bit_period(fs, rb, t, oe);
        if (oe) oe_cnt++;
        if (!oe && t) t_bad++;
        if (ins) begin
          got[W-1-(p-st)] = t;
          if (!oe) oe_bad++;
        end else if (oe) oe_bad++;
      end
      @(posedge clk);
      if (f == 0 && !mb) begin
        check(oe_cnt == 0, "R1 no drive before first sync", oe_cnt, 0);
        check(vcount == vstart, "R1 no strobe before first sync", vcount - vstart, 0);
      end else if (f >= 1 && f != gap_f + 1) begin
        check(oe_bad == 0, "R4 enable only in own slot (R3 position)", oe_bad, 0);
        check(t_bad == 0, "R9 line low when not enabled", t_bad, 0);
        check(got == txw, "R5 transmitted word", got, txw);
        check(vcount - vstart == 1, "R6 one strobe per frame", vcount - vstart, 1);
        check(last_rx == rxw, "R6 received word", last_rx, rxw);
        good = (oe_bad == 0) && (got == txw) && (last_rx == rxw) && (vcount - vstart == 1);
        if (f == 1) check(good, mb ? "R2 same-period alignment" : "R2 early-sync alignment", good, 1);
        if (f == drop_f || f == drop_f + 1) check(good, "R7 aligned across missing sync", good, 1);
        if (f == gap_f + 2) check(good, "R8 realigned after shifted sync", good, 1);
      end
      if (f == gap_f) begin
        for (int g = 0; g < 5; g++) begin
          logic t2, oe2;
          bit_period(1'b0, 1'($urandom), t2, oe2);
        end
      end
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd_oe == 1'b0, "R1 reset enable", txd_oe, 0);
    check(txd == 1'b0, "R1 reset line", txd, 0);
    check(rx_valid == 1'b0, "R1 reset strobe", rx_valid, 0);
    check(rx_word == '0, "R1 reset word", rx_word, 0);
    run_config(1'b0, 0, 1, -1, -1);
    run_config(1'b1, 0, 1, -1, -1);
    run_config(1'b0, 7, 8, -1, -1);
    run_config(1'b1, 7, 8, -1, -1);
    run_config(1'b1, 0, 4, 3, -1);
    run_config(1'b0, 2, 4, 2, -1);
    run_config(1'b0, 1, 3, -1, 2);
    run_config(1'b1, 0, 2, -1, 2);
    for (int k = 0; k < 4; k++) begin
      int c, i;
      c = 1 + int'($urandom % MS);
      i = int'($urandom % c);
      run_config(1'($urandom), i, c, -1, -1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule